// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

This block turns 96 asynchronous event inputs into interrupt requests. The lines are grouped into three banks of 32. Line n sits in bank n/32 at bit n mod 32. Each input passes through a two-flop synchroniser. A configurable line has two select bits, one for rising edges and one for falling edges, and the two edge directions are recorded in two separate pending registers. Software acknowledges a line by writing ones to the pending register that holds it. Software can also inject an event on a line through a software event register.

A mask bit set to 1 lets a line reach its bit of the per-line interrupt vector. All unmasked requests are OR-ed onto a single combined output. A read-only line-type word, set by a parameter, marks each line as configurable or direct. A direct line skips the edge and pending logic: its synchronised input goes straight to its output, gated only by its mask bit. Registers are reached through a simple port. Writes take effect on the clock edge and reads return data combinationally from the address.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset, every select, mask and pending register reads 0, `irq_line` and `irq_any` are 0, and each line-type word reads its slice of the `LINE_CFG` parameter.
- R2: The byte offsets for bank b (0..2) are as follows. Rising select is at 0x20*b. Falling select is at 0x20*b+0x04. Software event is at 0x20*b+0x08. Rising pending is at 0x20*b+0x0C. Falling pending is at 0x20*b+0x10. Mask is at 0x80+0x10*b. Line type is at 0x3EC-0x04*b. Line n uses bit n mod 32 in bank n/32.
- R3: On a configurable line, a rising edge sets the rising pending bit if the rising select bit is 1, and a falling edge sets the falling pending bit if the falling select bit is 1. With both select bits set, both edges are caught. Because of the two-flop synchroniser, a pending bit is set on the third rising clock edge after the input changes.
- R4: Writing 1 to a pending bit clears it. Writing 0 leaves it unchanged.
- R5: If an edge sets a pending bit on the same clock edge as a write that clears it, the bit stays 1.
- R6: For a configurable line, `irq_line[n]` is (rising pending OR falling pending) AND mask. `irq_any` is the OR of all bits of `irq_line`.
- R7: Writing 1 to a software event bit sets the rising pending bit if rising is selected and the falling pending bit if falling is selected. With neither selected the write has no effect. The software event register always reads 0.
- R8: A direct line (line-type bit 0) drives `irq_line[n]` from its synchronised input AND its mask, two clock edges after the input changes. Its pending bits never set.
- R9: Writes to a line-type word do not change it.
- R10: Reads of undefined offsets return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 12 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| ext_in | input | 96 | Asynchronous event inputs |
| irq_line | output | 96 | Per-line masked interrupt requests |
| irq_any | output | 1 | OR of all `irq_line` bits |

## Verification
The bench targets the case where an edge and a clear land on the same clock edge. A design that gives the clear priority would lose that event, and the bench reads back a pending bit of 0 there. Separate tests cover each edge direction, including a line set for both edges. These show that a design that merges the two pending registers, or places a line at the wrong bank bit, reads back the wrong word. The software event case with no select bit set would expose a design that sets pending unconditionally. The direct line case would expose a design that latches direct inputs instead of passing them through.

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl #(
  parameter int NUM_BANKS = 3,
  parameter int BANK_W    = 32,
  parameter int ADDR_W    = 12,
  parameter logic [NUM_BANKS*BANK_W-1:0] LINE_CFG = 96'hFFFF_FFFF_FFFF_FFFF_3FFF_FFFF
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [BANK_W-1:0]             wdata,
  output logic [BANK_W-1:0]             rdata,
  input  logic [NUM_BANKS*BANK_W-1:0]   ext_in,
  output logic [NUM_BANKS*BANK_W-1:0]   irq_line,
  output logic                          irq_any
);
  localparam int NL          = NUM_BANKS * BANK_W;
  localparam int BANK_STRIDE = 'h20;
  localparam int MASK_BASE   = 'h80;
  localparam int MASK_STRIDE = 'h10;
  localparam int TYPE_TOP    = 'h3EC;

  logic [NL-1:0] sync1, sync2, prev;
  logic [NL-1:0] rsel, fsel, mask, rpend, fpend;
  logic [NL-1:0] sw_ev, rclr, fclr, rise_set, fall_set;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      prev  <= '0;
    end else begin
      sync1 <= ext_in;
      sync2 <= sync1;
      prev  <= sync2;
    end
  end

  assign rise_set = LINE_CFG & rsel & ((sync2 & ~prev) | sw_ev);
  assign fall_set = LINE_CFG & fsel & ((~sync2 & prev) | sw_ev);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rpend <= '0;
      fpend <= '0;
    end else begin
      rpend <= (rpend & ~rclr) | rise_set;
      fpend <= (fpend & ~fclr) | fall_set;
    end
  end

  assign irq_line = mask & ((LINE_CFG & (rpend | fpend)) | (~LINE_CFG & sync2));
  assign irq_any  = |irq_line;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [ADDR_W-1:0] A_RSEL = ADDR_W'(b * BANK_STRIDE);
    localparam logic [ADDR_W-1:0] A_FSEL = ADDR_W'(b * BANK_STRIDE + 'h04);
    localparam logic [ADDR_W-1:0] A_SWEV = ADDR_W'(b * BANK_STRIDE + 'h08);
    localparam logic [ADDR_W-1:0] A_RPND = ADDR_W'(b * BANK_STRIDE + 'h0C);
    localparam logic [ADDR_W-1:0] A_FPND = ADDR_W'(b * BANK_STRIDE + 'h10);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(MASK_BASE + b * MASK_STRIDE);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rsel[b*BANK_W +: BANK_W] <= '0;
        fsel[b*BANK_W +: BANK_W] <= '0;
        mask[b*BANK_W +: BANK_W] <= '0;
      end else if (wr_en) begin
        if (addr == A_RSEL) rsel[b*BANK_W +: BANK_W] <= wdata;
        if (addr == A_FSEL) fsel[b*BANK_W +: BANK_W] <= wdata;
        if (addr == A_MASK) mask[b*BANK_W +: BANK_W] <= wdata;
      end
    end

    assign sw_ev[b*BANK_W +: BANK_W] = (wr_en && addr == A_SWEV) ? wdata : '0;
    assign rclr[b*BANK_W +: BANK_W]  = (wr_en && addr == A_RPND) ? wdata : '0;
    assign fclr[b*BANK_W +: BANK_W]  = (wr_en && addr == A_FPND) ? wdata : '0;

    AST_RPEND_W1C: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_RPND) |=>
        ((rpend[b*BANK_W +: BANK_W] & $past(wdata & ~rise_set[b*BANK_W +: BANK_W])) == '0)); // R4
    AST_FPEND_W1C: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_FPND) |=>
        ((fpend[b*BANK_W +: BANK_W] & $past(wdata & ~fall_set[b*BANK_W +: BANK_W])) == '0)); // R4
  end

  always_comb begin
    rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (addr == ADDR_W'(b * BANK_STRIDE))          rdata = rsel[b*BANK_W +: BANK_W];
      if (addr == ADDR_W'(b * BANK_STRIDE + 'h04))   rdata = fsel[b*BANK_W +: BANK_W];
      if (addr == ADDR_W'(b * BANK_STRIDE + 'h0C))   rdata = rpend[b*BANK_W +: BANK_W];
      if (addr == ADDR_W'(b * BANK_STRIDE + 'h10))   rdata = fpend[b*BANK_W +: BANK_W];
      if (addr == ADDR_W'(MASK_BASE + b * MASK_STRIDE)) rdata = mask[b*BANK_W +: BANK_W];
      if (addr == ADDR_W'(TYPE_TOP - 4 * b))         rdata = LINE_CFG[b*BANK_W +: BANK_W];
    end
  end

  AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise_set) |=> ((rpend & $past(rise_set)) == $past(rise_set))); // R5
  AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((rpend & $past(rpend & ~rclr)) == $past(rpend & ~rclr))); // R4
  AST_MASK_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_line & ~mask) == '0)); // R6
  AST_DIRECT_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (((rpend | fpend) & ~LINE_CFG) == '0)); // R8
endmodule

// File: tb/edge_irq_ctrl_tb.sv
module edge_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [95:0] ext_in = '0;
  logic [95:0] irq_line;
  logic        irq_any;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  edge_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ext_in(ext_in), .irq_line(irq_line), .irq_any(irq_any)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input string req, input logic [11:0] a, input logic [31:0] exp);
    addr = a;
    #1;
    chk(req, rdata, exp);
  endtask

  task automatic t_reset;
    rd("R1 rsel0", 12'h000, 32'h0);
    rd("R1 fsel1", 12'h024, 32'h0);
    rd("R1 rpend2", 12'h04C, 32'h0);
    rd("R1 mask0", 12'h080, 32'h0);
    chk("R1 irq_any", {31'h0, irq_any}, 32'h0);
    rd("R1 type0", 12'h3EC, 32'h3FFF_FFFF);
    rd("R1 type2", 12'h3E4, 32'hFFFF_FFFF);
  endtask

  task automatic t_rise;
    wr(12'h000, 32'h0000_0020);
    wr(12'h080, 32'h0000_0020);
    ext_in[5] = 1'b1;
    tick(2);
    chk("R3 not yet after two edges", {31'h0, irq_line[5]}, 32'h0);
    tick(1);
    rd("R3 rising pending line5", 12'h00C, 32'h0000_0020);
    rd("R3 falling pending empty", 12'h010, 32'h0);
    chk("R6 irq_line5", {31'h0, irq_line[5]}, 32'h1);
    chk("R6 irq_any", {31'h0, irq_any}, 32'h1);
    ext_in[5] = 1'b0;
    tick(3);
    rd("R3 fall ignored without fsel", 12'h010, 32'h0);
    wr(12'h00C, 32'h0);
    rd("R4 zero write keeps", 12'h00C, 32'h0000_0020);
    wr(12'h00C, 32'h0000_0020);
    rd("R4 one write clears", 12'h00C, 32'h0);
    chk("R6 irq_any after clear", {31'h0, irq_any}, 32'h0);
  endtask

  task automatic t_edges_banks;
    wr(12'h024, 32'h0000_0100);
    wr(12'h090, 32'h0000_0100);
    ext_in[40] = 1'b1;
    tick(3);
    rd("R2 line40 no rising pend", 12'h02C, 32'h0);
    ext_in[40] = 1'b0;
    tick(3);
    rd("R2 line40 falling pend", 12'h030, 32'h0000_0100);
    chk("R6 irq_line40", {31'h0, irq_line[40]}, 32'h1);
    wr(12'h040, 32'h0000_0040);
    wr(12'h044, 32'h0000_0040);
    ext_in[70] = 1'b1;
    tick(3);
    rd("R3 both-edge rise", 12'h04C, 32'h0000_0040);
    ext_in[70] = 1'b0;
    tick(3);
    rd("R3 both-edge fall", 12'h050, 32'h0000_0040);
    chk("R6 masked line70", {31'h0, irq_line[70]}, 32'h0);
    wr(12'h0A0, 32'h0000_0040);
    chk("R6 unmasked line70", {31'h0, irq_line[70]}, 32'h1);
    wr(12'h030, 32'hFFFF_FFFF);
    wr(12'h04C, 32'hFFFF_FFFF);
    wr(12'h050, 32'hFFFF_FFFF);
    chk("R4 all cleared", {31'h0, irq_any}, 32'h0);
  endtask

  task automatic t_edge_wins;
    ext_in[5] = 1'b1;
    tick(3);
    ext_in[5] = 1'b0;
    tick(3);
    rd("R5 setup pending", 12'h00C, 32'h0000_0020);
    ext_in[5] = 1'b1;
    tick(2);
    wr(12'h00C, 32'h0000_0020);
    rd("R5 edge beats clear", 12'h00C, 32'h0000_0020);
    wr(12'h00C, 32'h0000_0020);
    rd("R5 later clear works", 12'h00C, 32'h0);
  endtask

  task automatic t_swev;
    wr(12'h000, 32'h0000_0060);
    wr(12'h008, 32'h0000_00C0);
    rd("R7 sw rising line6 only", 12'h00C, 32'h0000_0040);
    rd("R7 sw no falling bank0", 12'h010, 32'h0);
    rd("R7 sw reg reads zero", 12'h008, 32'h0);
    wr(12'h024, 32'h0000_0200);
    wr(12'h028, 32'h0000_0200);
    rd("R7 sw falling line41", 12'h030, 32'h0000_0200);
    rd("R7 sw no rising line41", 12'h02C, 32'h0);
    wr(12'h00C, 32'hFFFF_FFFF);
    wr(12'h030, 32'hFFFF_FFFF);
  endtask

  task automatic t_direct;
    wr(12'h000, 32'h4000_0020);
    wr(12'h080, 32'h4000_0020);
    ext_in[30] = 1'b1;
    tick(1);
    chk("R8 direct not after one edge", {31'h0, irq_line[30]}, 32'h0);
    tick(1);
    chk("R8 direct passes", {31'h0, irq_line[30]}, 32'h1);
    tick(2);
    rd("R8 direct no pending", 12'h00C, 32'h0);
    ext_in[30] = 1'b0;
    tick(2);
    chk("R8 direct follows low", {31'h0, irq_line[30]}, 32'h0);
  endtask

  task automatic t_undef;
    wr(12'h3EC, 32'h0);
    rd("R9 type0 read-only", 12'h3EC, 32'h3FFF_FFFF);
    wr(12'h014, 32'hFFFF_FFFF);
    wr(12'h084, 32'hFFFF_FFFF);
    rd("R10 undef 0x14", 12'h014, 32'h0);
    rd("R10 undef 0x84", 12'h084, 32'h0);
    rd("R10 mask0 untouched", 12'h080, 32'h4000_0020);
    rd("R10 undef 0x3F0", 12'h3F0, 32'h0);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_rise();
    t_edges_banks();
    t_edge_wins();
    t_swev();
    t_direct();
    t_undef();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule